// File: doc/BRIEF.md
# Pointer Register Addressing Unit

This unit turns the contents of the 16-bit register pairs in the upper part of a byte-wide register file into data-memory addresses. A load or store request names one of three pointer pairs and one of four addressing modes: plain indirect, post-increment, pre-decrement, or base plus a small displacement. The unit returns the effective address, a memory strobe with its direction, and, where the mode changes the pointer, the new pointer value with a write-back enable.

The same datapath also adds or subtracts a 6-bit unsigned immediate to or from any of four fixed register pairs. It returns the 16-bit result for write-back and the five arithmetic flags. The register file, the data memory and program-memory reads live outside the unit. The caller drives the current value of every pair on the four pair inputs.

Each accepted request occupies the unit for two cycles. Requests that arrive while it is busy, and illegal combinations, are dropped without a response.

Top module: `ptru_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `done`, `mem_req`, `mem_we`, `wb_en` and `flag_we` are 0 and `addr` is 0.
- R2: Plain indirect (op code 0) sets `addr` to the selected pair value and leaves `wb_en` at 0.
- R3: Post-increment (op code 1) sets `addr` to the pair value, sets `wb_en` to 1 and sets `wb_val` to the pair value plus one, modulo 2^16.
- R4: Pre-decrement (op code 2) drives the pair value minus one, modulo 2^16, on both `addr` and `wb_val`, with `wb_en` at 1.
- R5: Displacement (op code 3) sets `addr` to the pair value plus the zero-extended 6-bit `req_imm`, modulo 2^16, and leaves `wb_en` at 0. It is legal only on the Y pair (select 2) and the Z pair (select 3).
- R6: The pair selects are 0 for R25:R24, 1 for X (R27:R26), 2 for Y (R29:R28) and 3 for Z (R31:R30). Any pointer mode on select 0, displacement on select 1, and op codes 6 and 7 are ignored: no strobe of any kind follows.
- R7: A request accepted at clock edge k gives `done` high for exactly the one cycle after edge k+1. A request presented in the cycle after acceptance is ignored.
- R8: Word add (op code 4) writes the pair value plus `req_imm` to `wb_val`, with `wb_en` at 1 and `wb_sel` equal to the select. With a = old bit 15 and r = result bit 15: C = a & ~r and V = ~a & r.
- R9: Word subtract (op code 5) writes the pair value minus `req_imm` to `wb_val`, with `wb_en` at 1. It sets C = ~a & r and V = a & ~r.
- R10: For word operations, Z is 1 exactly when all 16 result bits are zero, N is result bit 15, and S = N ^ V. In `flags`, bit 4 is S, bit 3 V, bit 2 N, bit 1 Z and bit 0 C.
- R11: Pointer modes give `mem_req` = 1, `mem_we` = `req_store`, `flag_we` = 0 and `wb_sel` = the select. Word operations give `mem_req` = 0 and `flag_we` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code (see R2 to R9) |
| req_sel | input | 2 | Register pair select (see R6) |
| req_store | input | 1 | 1 = store, 0 = load, for pointer modes |
| req_imm | input | 6 | Displacement or word immediate, 0 to 63 |
| pair0_val | input | 16 | Current value of R25:R24 |
| pair1_val | input | 16 | Current value of X |
| pair2_val | input | 16 | Current value of Y |
| pair3_val | input | 16 | Current value of Z |
| done | output | 1 | One-cycle result strobe |
| mem_req | output | 1 | Data-memory access strobe |
| mem_we | output | 1 | Access is a write |
| addr | output | 16 | Effective data address |
| wb_en | output | 1 | Pair write-back enable |
| wb_sel | output | 2 | Pair to write back |
| wb_val | output | 16 | Write-back value |
| flag_we | output | 1 | Flag update strobe |
| flags | output | 5 | {S,V,N,Z,C} |

## Verification
Every result becomes visible one full cycle after the accepting edge. The bench drives a request on a falling edge and removes it on the next falling edge. At that point it confirms `done` is still low, which shows the request is still in flight. It samples the results on the falling edge after that. The dropped-request checks watch every strobe for three cycles after the request. The back-to-back check holds `req_valid` high across the busy cycle and confirms that only one `done` pulse appears.

// File: rtl/ptru_pkg.sv
// Shared types for the pointer register addressing unit.
// Assumes four 16-bit register pairs, indexed 0..3 (R24, X, Y, Z).
package ptru_pkg;

    typedef enum logic [2:0] {
        PM_PLAIN   = 3'd0,
        PM_POSTINC = 3'd1,
        PM_PREDEC  = 3'd2,
        PM_DISP    = 3'd3,
        PM_WADD    = 3'd4,
        PM_WSUB    = 3'd5,
        PM_RSV6    = 3'd6,
        PM_RSV7    = 3'd7
    } ptru_op_e;

    typedef struct packed {
        logic s;
        logic v;
        logic n;
        logic z;
        logic c;
    } ptru_flags_t;

    localparam int PAIR_CNT = 4;
    localparam int SEL_W    = $clog2(PAIR_CNT);
    localparam logic [SEL_W-1:0] SEL_X = 2'd1;
    localparam logic [SEL_W-1:0] SEL_W0 = 2'd0;

endpackage

// File: rtl/ptru_req_stage.sv
// Request stage: checks that a request is legal, then latches the
// operation and the selected pair value into a one-deep stage.
// Assumes the caller drives every pair value on each cycle. busy_q is
// high for exactly one cycle per accepted request, and requests seen
// while busy_q is high are dropped.
module ptru_req_stage
    import ptru_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int IMM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [SEL_W-1:0] req_sel,
    input  logic             req_store,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [PTR_W-1:0] sel_val,
    output logic             busy_q,
    output ptru_op_e         op_q,
    output logic [SEL_W-1:0] sel_q,
    output logic             store_q,
    output logic [IMM_W-1:0] imm_q,
    output logic [PTR_W-1:0] val_q
);

    logic legal;
    logic accept;

    // Legality: pointer modes need a pointer pair, displacement needs Y or Z
    always_comb begin
        unique case (ptru_op_e'(req_op))
            PM_PLAIN, PM_POSTINC, PM_PREDEC: legal = (req_sel != SEL_W0);
            PM_DISP:                         legal = (req_sel != SEL_W0) && (req_sel != SEL_X);
            PM_WADD, PM_WSUB:                legal = 1'b1;
            default:                         legal = 1'b0;
        endcase
    end

    assign accept = req_valid && !busy_q && legal;

    // Occupancy flag: set for the single cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= accept;
    end

    // Operand capture on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= PM_PLAIN;
            sel_q   <= '0;
            store_q <= 1'b0;
            imm_q   <= '0;
            val_q   <= '0;
        end else if (accept) begin
            op_q    <= ptru_op_e'(req_op);
            sel_q   <= req_sel;
            store_q <= req_store;
            imm_q   <= req_imm;
            val_q   <= sel_val;
        end
    end

endmodule

// File: rtl/ptru_addr_calc.sv
// Address generator for the four pointer modes. It is purely
// combinational and works on the captured pair value. All arithmetic
// wraps modulo 2^PTR_W.
module ptru_addr_calc
    import ptru_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int IMM_W = 6
) (
    input  ptru_op_e         op,
    input  logic [PTR_W-1:0] base,
    input  logic [IMM_W-1:0] disp,
    output logic [PTR_W-1:0] eff_addr,
    output logic [PTR_W-1:0] new_ptr,
    output logic             ptr_upd
);

    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    logic [PTR_W-1:0] inc_v;
    logic [PTR_W-1:0] dec_v;
    logic [PTR_W-1:0] dsp_v;

    assign inc_v = base + ONE;
    assign dec_v = base - ONE;
    assign dsp_v = base + {{(PTR_W-IMM_W){1'b0}}, disp};

    // Mode select: address seen by memory and pointer write-back
    always_comb begin
        eff_addr = base;
        new_ptr  = base;
        ptr_upd  = 1'b0;
        unique case (op)
            PM_POSTINC: begin
                new_ptr = inc_v;
                ptr_upd = 1'b1;
            end
            PM_PREDEC: begin
                eff_addr = dec_v;
                new_ptr  = dec_v;
                ptr_upd  = 1'b1;
            end
            PM_DISP:  eff_addr = dsp_v;
            default:  ;
        endcase
    end

endmodule

// File: rtl/ptru_word_alu.sv
// Word add/subtract of a zero-extended immediate, with flag generation.
// C and V come from the old and new most significant bits only.
module ptru_word_alu
    import ptru_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int IMM_W = 6
) (
    input  logic             do_sub,
    input  logic [PTR_W-1:0] opnd,
    input  logic [IMM_W-1:0] imm,
    output logic [PTR_W-1:0] result,
    output ptru_flags_t      flg
);

    localparam int MSB = PTR_W - 1;

    logic [PTR_W-1:0] ext_imm;
    logic             a_hi;
    logic             r_hi;

    assign ext_imm = {{(PTR_W-IMM_W){1'b0}}, imm};

    // Sum or difference
    always_comb begin
        if (do_sub) result = opnd - ext_imm;
        else        result = opnd + ext_imm;
    end

    assign a_hi = opnd[MSB];
    assign r_hi = result[MSB];

    // Flags derived from operand and result sign bits
    always_comb begin
        flg.z = (result == '0);
        flg.n = r_hi;
        if (do_sub) begin
            flg.c = r_hi & ~a_hi;
            flg.v = a_hi & ~r_hi;
        end else begin
            flg.c = a_hi & ~r_hi;
            flg.v = ~a_hi & r_hi;
        end
        flg.s = flg.n ^ flg.v;
    end

endmodule

// File: rtl/ptru_top.sv
// Pointer register addressing unit top. It selects a pair, passes the
// request through the one-deep stage, computes the pointer address or
// the word result, and registers every output. Outputs are valid during
// the cycle in which done is high. The strobes are 0 in all other cycles
// and the data outputs hold their last value.
module ptru_top
    import ptru_pkg::*;
#(
    parameter int PTR_W = 16,
    parameter int IMM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_sel,
    input  logic             req_store,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [PTR_W-1:0] pair0_val,
    input  logic [PTR_W-1:0] pair1_val,
    input  logic [PTR_W-1:0] pair2_val,
    input  logic [PTR_W-1:0] pair3_val,
    output logic             done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PTR_W-1:0] addr,
    output logic             wb_en,
    output logic [1:0]       wb_sel,
    output logic [PTR_W-1:0] wb_val,
    output logic             flag_we,
    output logic [4:0]       flags
);

    logic [PTR_W-1:0] pair_arr [PAIR_CNT];
    logic [PTR_W-1:0] sel_val;
    logic             busy_q;
    ptru_op_e         op_q;
    logic [SEL_W-1:0] sel_q;
    logic             store_q;
    logic [IMM_W-1:0] imm_q;
    logic [PTR_W-1:0] val_q;
    logic [PTR_W-1:0] ag_addr;
    logic [PTR_W-1:0] ag_ptr;
    logic             ag_upd;
    logic [PTR_W-1:0] alu_res;
    ptru_flags_t      alu_flg;
    logic             is_word;

    assign pair_arr[0] = pair0_val;
    assign pair_arr[1] = pair1_val;
    assign pair_arr[2] = pair2_val;
    assign pair_arr[3] = pair3_val;
    assign sel_val     = pair_arr[req_sel];

    ptru_req_stage #(.PTR_W(PTR_W), .IMM_W(IMM_W)) stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_sel   (req_sel),
        .req_store (req_store),
        .req_imm   (req_imm),
        .sel_val   (sel_val),
        .busy_q    (busy_q),
        .op_q      (op_q),
        .sel_q     (sel_q),
        .store_q   (store_q),
        .imm_q     (imm_q),
        .val_q     (val_q)
    );

    ptru_addr_calc #(.PTR_W(PTR_W), .IMM_W(IMM_W)) agen_i (
        .op       (op_q),
        .base     (val_q),
        .disp     (imm_q),
        .eff_addr (ag_addr),
        .new_ptr  (ag_ptr),
        .ptr_upd  (ag_upd)
    );

    ptru_word_alu #(.PTR_W(PTR_W), .IMM_W(IMM_W)) walu_i (
        .do_sub (op_q == PM_WSUB),
        .opnd   (val_q),
        .imm    (imm_q),
        .result (alu_res),
        .flg    (alu_flg)
    );

    assign is_word = (op_q == PM_WADD) || (op_q == PM_WSUB);

    // Strobe register: one-cycle pulses qualified by the stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            wb_en   <= 1'b0;
            flag_we <= 1'b0;
        end else begin
            done    <= busy_q;
            mem_req <= busy_q && !is_word;
            mem_we  <= busy_q && !is_word && store_q;
            wb_en   <= busy_q && (is_word || ag_upd);
            flag_we <= busy_q && is_word;
        end
    end

    // Data register: loaded while a request is in the stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            wb_sel <= '0;
            wb_val <= '0;
            flags  <= '0;
        end else if (busy_q) begin
            wb_sel <= sel_q;
            if (is_word) begin
                wb_val <= alu_res;
                flags  <= alu_flg;
            end else begin
                addr   <= ag_addr;
                wb_val <= ag_ptr;
            end
        end
    end

endmodule

// File: rtl/ptru_checker.sv
// Temporal checks on the pointer addressing unit, bound to ptru_top.
module ptru_checker #(
    parameter int PTR_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_q,
    input logic             done,
    input logic             mem_req,
    input logic             mem_we,
    input logic [PTR_W-1:0] addr,
    input logic             wb_en,
    input logic [PTR_W-1:0] wb_val,
    input logic             flag_we,
    input logic [4:0]       flags
);

    AST_STAGE_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> done) else $error("stage did not complete"); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done held two cycles"); // R7

    AST_STROBE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || mem_we || wb_en || flag_we) |-> done) else $error("stray strobe"); // R11

    AST_WE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req) else $error("write without access"); // R11

    AST_WORD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (!mem_req && wb_en)) else $error("word op touched memory"); // R11

    AST_SIGN_XOR: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (flags[4] == (flags[3] ^ flags[2]))) else $error("S flag"); // R10

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && wb_en) |-> ((wb_val == addr + PTR_W'(1)) || (wb_val == addr)))
        else $error("pointer step"); // R3

endmodule

bind ptru_top ptru_checker #(.PTR_W(PTR_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy_q  (busy_q),
    .done    (done),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .addr    (addr),
    .wb_en   (wb_en),
    .wb_val  (wb_val),
    .flag_we (flag_we),
    .flags   (flags)
);

// File: tb/ptru_top_tb_top.sv
module ptru_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [1:0]  req_sel = '0;
    logic        req_store = 1'b0;
    logic [5:0]  req_imm = '0;
    logic [15:0] pv0 = '0, pv1 = '0, pv2 = '0, pv3 = '0;
    logic        done, mem_req, mem_we, wb_en, flag_we;
    logic [15:0] addr, wb_val;
    logic [1:0]  wb_sel;
    logic [4:0]  flags;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ptru_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_store(req_store), .req_imm(req_imm),
        .pair0_val(pv0), .pair1_val(pv1), .pair2_val(pv2), .pair3_val(pv3),
        .done(done), .mem_req(mem_req), .mem_we(mem_we), .addr(addr),
        .wb_en(wb_en), .wb_sel(wb_sel), .wb_val(wb_val),
        .flag_we(flag_we), .flags(flags)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  sel;
        logic        st;
        logic [5:0]  imm;
        logic [15:0] val;
        logic [15:0] eaddr;
        logic        ewb;
        logic [15:0] ewbv;
        logic [4:0]  eflg;
    } vec_t;

    // op, sel, store, imm, pair value, addr, wb_en, wb_val, flags {S,V,N,Z,C}
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd2, 1'b0, 6'd0,  16'h1234, 16'h1234, 1'b0, 16'h0000, 5'b00000}, // R2
        '{3'd1, 2'd1, 1'b1, 6'd0,  16'h00FF, 16'h00FF, 1'b1, 16'h0100, 5'b00000}, // R3
        '{3'd1, 2'd3, 1'b0, 6'd0,  16'hFFFF, 16'hFFFF, 1'b1, 16'h0000, 5'b00000}, // R3 wrap
        '{3'd2, 2'd1, 1'b0, 6'd0,  16'h0000, 16'hFFFF, 1'b1, 16'hFFFF, 5'b00000}, // R4 wrap
        '{3'd2, 2'd2, 1'b1, 6'd0,  16'h8000, 16'h7FFF, 1'b1, 16'h7FFF, 5'b00000}, // R4
        '{3'd3, 2'd3, 1'b0, 6'd63, 16'h1000, 16'h103F, 1'b0, 16'h0000, 5'b00000}, // R5 max q
        '{3'd3, 2'd2, 1'b1, 6'd32, 16'hFFF0, 16'h0010, 1'b0, 16'h0000, 5'b00000}, // R5 wrap
        '{3'd4, 2'd0, 1'b0, 6'd1,  16'h00FF, 16'h0000, 1'b1, 16'h0100, 5'b00000}, // R8
        '{3'd4, 2'd1, 1'b0, 6'd1,  16'h7FFF, 16'h0000, 1'b1, 16'h8000, 5'b01100}, // R8 V
        '{3'd4, 2'd2, 1'b0, 6'd63, 16'hFFC1, 16'h0000, 1'b1, 16'h0000, 5'b00011}, // R8 C,Z
        '{3'd5, 2'd3, 1'b0, 6'd1,  16'h0000, 16'h0000, 1'b1, 16'hFFFF, 5'b10101}, // R9 C,N,S
        '{3'd5, 2'd0, 1'b0, 6'd1,  16'h8000, 16'h0000, 1'b1, 16'h7FFF, 5'b11000}, // R9 V,S
        '{3'd5, 2'd1, 1'b0, 6'd5,  16'h0005, 16'h0000, 1'b1, 16'h0000, 5'b00010}  // R10 Z
    };

    task automatic chk(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; return in the cycle results are visible
    task automatic issue(input logic [2:0] op, input logic [1:0] sel, input logic st,
                         input logic [5:0] imm, input logic [15:0] val);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_sel = sel; req_store = st; req_imm = imm;
        pv0 = 16'hA5A5; pv1 = 16'hA5A5; pv2 = 16'hA5A5; pv3 = 16'hA5A5;
        case (sel)
            2'd0: pv0 = val;
            2'd1: pv1 = val;
            2'd2: pv2 = val;
            default: pv3 = val;
        endcase
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0, "R7 early", {15'd0, done}, 16'd0);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({done, mem_req, mem_we, wb_en, flag_we} == 5'd0, "R1 strobes in reset",
            {11'd0, done, mem_req, mem_we, wb_en, flag_we}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({done, mem_req, mem_we, wb_en, flag_we} == 5'd0 && addr == 16'd0,
            "R1 after release", addr, 16'd0);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            bit is_w;
            v = VECS[i];
            is_w = (v.op == 3'd4) || (v.op == 3'd5);
            issue(v.op, v.sel, v.st, v.imm, v.val);
            chk(done == 1'b1, "R7 done", {15'd0, done}, 16'd1);
            chk(wb_en == v.ewb, "R2-5/R8 wb_en", {15'd0, wb_en}, {15'd0, v.ewb});
            chk(wb_sel == v.sel, "R11 wb_sel", {14'd0, wb_sel}, {14'd0, v.sel});
            if (v.ewb)
                chk(wb_val == v.ewbv, "R3 R4 R8 R9 wb_val", wb_val, v.ewbv);
            if (is_w) begin
                chk(flag_we && !mem_req, "R11 word strobes",
                    {14'd0, flag_we, mem_req}, 16'd2);
                chk(flags == v.eflg, "R8 R9 R10 flags", {11'd0, flags}, {11'd0, v.eflg});
            end else begin
                chk(addr == v.eaddr, "R2 R3 R4 R5 addr", addr, v.eaddr);
                chk(mem_req && !flag_we && mem_we == v.st, "R11 ptr strobes",
                    {13'd0, mem_req, mem_we, flag_we}, {13'd0, 1'b1, v.st, 1'b0});
            end
            @(negedge clk);
            chk(!done, "R7 single pulse", {15'd0, done}, 16'd0);
        end

        // R6: illegal requests produce nothing
        for (int k = 0; k < 3; k++) begin
            logic [2:0] bop;
            logic [1:0] bsel;
            int seen;
            bop  = (k == 0) ? 3'd3 : (k == 1) ? 3'd0 : 3'd7;
            bsel = (k == 0) ? 2'd1 : (k == 1) ? 2'd0 : 2'd2;
            seen = 0;
            @(negedge clk);
            req_valid = 1'b1; req_op = bop; req_sel = bsel; req_store = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            for (int c = 0; c < 3; c++) begin
                if (done || mem_req || mem_we || wb_en || flag_we) seen++;
                @(negedge clk);
            end
            chk(seen == 0, "R6 ignored request", seen[15:0], 16'd0);
        end

        // R7: request held across the busy cycle yields one pulse
        begin
            int pulses;
            pulses = 0;
            @(negedge clk);
            req_valid = 1'b1; req_op = 3'd1; req_sel = 2'd2; req_store = 1'b0;
            pv2 = 16'h0040;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            for (int c = 0; c < 4; c++) begin
                if (done) pulses++;
                @(negedge clk);
            end
            chk(pulses == 1, "R7 busy drop", pulses[15:0], 16'd1);
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule